// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets synchronous logic read and write a 128K x 16 asynchronous static RAM one word at a time. A request is presented with a valid/ready handshake. It carries a 17-bit word address, 16 bits of write data, two lane-enable bits (bit 0 for the low byte, bit 1 for the high byte) and a write flag. The controller turns each request into a memory cycle on active-low chip-select, read-strobe, write-strobe and per-lane strobe pins. It drives the data bus through a split output, output-enable and input triple, which a pad ring joins into one tristate bus.

Each strobe is held for a whole number of clock cycles. These counts are derived at elaboration from the nanosecond minima of the chosen speed grade (`GRADE` 0 is the 70 ns set, 1 is the 85 ns set) and from the clock period `CLK_NS`. For a minimum of `t` ns the count is `max(1, ceil(t/CLK_NS))`. The read hold is `RD = cyc(read cycle)`. The write-strobe hold is `WP = max(cyc(write pulse), cyc(lane valid to end), cyc(address valid to end), cyc(data setup)+1)`, where the pulse, lane and address minima are 55/60/65 ns fast and 60/70/70 ns slow, and setup is 30/35 ns. The recovery is `REC = max(1, cyc(write cycle) - WP)`. Every request gets a single-cycle response pulse. For reads that pulse carries the data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and after its release: chip-select, read-strobe, write-strobe and both lane strobes are high. The data-drive enable is low, ready is high and response valid is low.
- R2: A read with a nonzero lane mask holds chip-select and read-strobe low with write-strobe high for exactly RD cycles, starting in the cycle after acceptance. In the cycle after, all strobes are high and response valid is high for one cycle.
- R3: The lane strobes follow the inverted mask: the low strobe from mask bit 0 gates data bits 7:0, and the high strobe from mask bit 1 gates bits 15:8. Read data is sampled in the last strobe cycle, and a lane whose strobe stayed high returns zero.
- R4: A write with a nonzero mask holds chip-select and write-strobe low for exactly WP cycles, with the read-strobe high throughout. Chip-select, write-strobe and the lane strobes all rise on the same edge.
- R5: For a write, the data-drive enable is high from the second cycle of the write-strobe pulse through the first cycle after it rises, WP cycles in total. While it is high the data output equals the request's write data.
- R6: The data-drive enable is never high while the read-strobe is low.
- R7: Ready is high when idle. After acceptance of a request with a nonzero mask, ready is low for RD cycles for a read and WP+REC cycles for a write. Response valid comes in the first cycle ready is high again.
- R8: A request with both mask bits clear causes no strobe activity and keeps ready high. Response valid follows in the next cycle, with read data zero.
- R9: With CLK_NS=4, the fast set gives RD=18, WP=17, REC=1, and the slow set gives RD=22, WP=18, REC=4.
- R10: The memory address equals the accepted request address, and it does not change while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_no | output | 1 | Chip-select, active low |
| mem_rd_no | output | 1 | Read-strobe (output enable), active low |
| mem_wr_no | output | 1 | Write-strobe, active low |
| mem_hi_no | output | 1 | High lane strobe, active low |
| mem_lo_no | output | 1 | Low lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Data-drive enable |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
The hardest case to reach is a write that ends with the data still valid on the terminating edge. A partial-lane write must land only in its own byte, and no other lane may be disturbed. A memory model in the bench records the overlap of chip-select, write-strobe and a lane strobe. It commits the data only when that overlap ends, taking only the lanes whose strobe was low. Undriven data shows up as a garbage byte in the model. The sweep writes every mask to several addresses and then reads each address back under every mask. Corrupted, mistimed or misplaced lanes therefore show up at the response port.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef struct packed {
    int unsigned rc;   // read cycle
    int unsigned wc;   // write cycle
    int unsigned pwe;  // write strobe width
    int unsigned pwb;  // lane strobe to write end
    int unsigned aw;   // address valid to write end
    int unsigned sd;   // data setup to write end
  } grade_ns_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WPULSE, ST_WREC} seq_st_t;

  function automatic grade_ns_t grade_ns(input int unsigned grade);
    grade_ns_t t;
    if (grade == 0) begin
      t.rc = 70; t.wc = 70; t.pwe = 55; t.pwb = 60; t.aw = 65; t.sd = 30;
    end else begin
      t.rc = 85; t.wc = 85; t.pwe = 60; t.pwb = 70; t.aw = 70; t.sd = 35;
    end
    return t;
  endfunction

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES = 2,
  parameter int unsigned N_RD  = 18,
  parameter int unsigned N_WP  = 17,
  parameter int unsigned N_REC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic [LANES-1:0] req_be_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             rsp_valid_o,
  output logic             cs_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic [LANES-1:0] lane_no,
  output logic             drive_o
);

  localparam int unsigned CMAX = umax(umax(N_RD, N_WP), N_REC);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  seq_st_t         st_q;
  logic [CW-1:0]   cnt_q;
  logic            last;

  assign ready_o   = (st_q == ST_IDLE);
  assign accept_o  = req_valid_i & ready_o;
  assign last      = (cnt_q == '0);
  assign capture_o = (st_q == ST_READ) & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      cs_no       <= 1'b1;
      rd_no       <= 1'b1;
      wr_no       <= 1'b1;
      lane_no     <= '1;
      drive_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_o) begin
            if (req_be_i == '0) begin
              rsp_valid_o <= 1'b1;
            end else if (req_we_i) begin
              st_q    <= ST_WPULSE;
              cnt_q   <= CW'(N_WP - 1);
              cs_no   <= 1'b0;
              wr_no   <= 1'b0;
              lane_no <= ~req_be_i;
            end else begin
              st_q    <= ST_READ;
              cnt_q   <= CW'(N_RD - 1);
              cs_no   <= 1'b0;
              rd_no   <= 1'b0;
              lane_no <= ~req_be_i;
            end
          end
        end
        ST_READ: begin
          if (last) begin
            st_q        <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            cs_no       <= 1'b1;
            rd_no       <= 1'b1;
            lane_no     <= '1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WPULSE: begin
          drive_o <= 1'b1;  // only once write-strobe is already low
          if (last) begin
            st_q    <= ST_WREC;
            cnt_q   <= CW'(N_REC - 1);
            cs_no   <= 1'b1;
            wr_no   <= 1'b1;
            lane_no <= '1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin  // ST_WREC: drivers held one cycle past write end
          drive_o <= 1'b0;
          if (last) begin
            st_q        <= ST_IDLE;
            rsp_valid_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  // Write-strobe low-time monitor
  logic [CW-1:0] wr_lo_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wr_lo_q <= '0;
    else if (!wr_no) wr_lo_q <= wr_lo_q + 1'b1;
    else             wr_lo_q <= '0;
  end

  assert_wr_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (wr_lo_q == CW'(N_WP)));

  assert_wr_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (!cs_no && rd_no && !(&lane_no)));

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> rd_no);

  assert_drive_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> (!wr_no || $past(!wr_no)));

  assert_rsp_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_idle_strobes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (wr_no && rd_no && (&lane_no)));

endmodule

// File: rtl/sram_lane_dq.sv
module sram_lane_dq #(
  parameter int unsigned AW     = 17,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [LANES-1:0] lane_ni,
  input  logic [DW-1:0]    dq_i,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [DW-1:0]    rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_o[l*LANE_W +: LANE_W] <= '0;
      end else if (accept_i) begin
        rdata_o[l*LANE_W +: LANE_W] <= '0;
      end else if (capture_i) begin
        rdata_o[l*LANE_W +: LANE_W] <= lane_ni[l] ? '0 : dq_i[l*LANE_W +: LANE_W];
      end
    end

    assert_lane_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(capture_i) && $past(lane_ni[l])) |-> (rdata_o[l*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned CLK_NS = 4,
  parameter int unsigned GRADE  = 0,
  parameter int unsigned AW     = 17,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [2*LANE_W-1:0]   req_wdata_i,
  input  logic [1:0]            req_be_i,
  output logic                  rsp_valid_o,
  output logic [2*LANE_W-1:0]   rsp_rdata_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic                  mem_cs_no,
  output logic                  mem_rd_no,
  output logic                  mem_wr_no,
  output logic                  mem_hi_no,
  output logic                  mem_lo_no,
  output logic [2*LANE_W-1:0]   mem_dq_o,
  output logic                  mem_dq_oe_o,
  input  logic [2*LANE_W-1:0]   mem_dq_i
);

  localparam int unsigned LANES = 2;
  localparam grade_ns_t   T     = grade_ns(GRADE);
  localparam int unsigned N_RD  = ns2cyc(T.rc, CLK_NS);
  localparam int unsigned N_WP  = umax(umax(ns2cyc(T.pwe, CLK_NS), ns2cyc(T.pwb, CLK_NS)),
                                       umax(ns2cyc(T.aw, CLK_NS), ns2cyc(T.sd, CLK_NS) + 1));
  localparam int unsigned N_WC  = ns2cyc(T.wc, CLK_NS);
  localparam int unsigned N_REC = (N_WC > N_WP) ? (N_WC - N_WP) : 1;

  logic             accept;
  logic             capture;
  logic [LANES-1:0] lane_n;

  sram_lane_seq #(
    .LANES (LANES),
    .N_RD  (N_RD),
    .N_WP  (N_WP),
    .N_REC (N_REC)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_be_i    (req_be_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .rsp_valid_o (rsp_valid_o),
    .cs_no       (mem_cs_no),
    .rd_no       (mem_rd_no),
    .wr_no       (mem_wr_no),
    .lane_no     (lane_n),
    .drive_o     (mem_dq_oe_o)
  );

  sram_lane_dq #(
    .AW     (AW),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_dq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .lane_ni     (lane_n),
    .dq_i        (mem_dq_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_dq_o),
    .rdata_o     (rsp_rdata_o)
  );

  assign mem_lo_no = lane_n[0];
  assign mem_hi_no = lane_n[1];

  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  assert_lanes_need_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&lane_n) |-> !mem_cs_no);

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_NS = 4;
  localparam int GRADE  = 0;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R9: cycle counts from the nanosecond minima
  localparam int RC  = GRADE == 0 ? 70 : 85;
  localparam int PWE = GRADE == 0 ? 55 : 60;
  localparam int PWB = GRADE == 0 ? 60 : 70;
  localparam int AWN = GRADE == 0 ? 65 : 70;
  localparam int SD  = GRADE == 0 ? 30 : 35;
  localparam int E_RD  = cyc(RC);
  localparam int E_WP  = mx(mx(cyc(PWE), cyc(PWB)), mx(cyc(AWN), cyc(SD) + 1));
  localparam int E_REC = (cyc(RC) > E_WP) ? cyc(RC) - E_WP : 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, rsp_valid, cs_n, rd_n, wr_n, hi_n, lo_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [16:0] maddr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mem [256];
  logic [15:0] shadow [256];

  always #(CLK_NS / 2) clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS), .GRADE(GRADE)) i_sram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_be_i(be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_cs_no(cs_n), .mem_rd_no(rd_n), .mem_wr_no(wr_n),
    .mem_hi_no(hi_n), .mem_lo_no(lo_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i)
  );

  // Memory model: lanes drive only when selected for read; undriven lanes float to junk
  assign dq_i[15:8] = (!cs_n && !rd_n && wr_n && !hi_n) ? mem[maddr[7:0]][15:8] : 8'hA5;
  assign dq_i[7:0]  = (!cs_n && !rd_n && wr_n && !lo_n) ? mem[maddr[7:0]][7:0]  : 8'h5A;

  bit pend = 0, p_drv, p_hi, p_lo;
  logic [7:0]  p_a;
  logic [15:0] p_d;
  always @(negedge clk) begin
    if (!cs_n && !wr_n && !(hi_n && lo_n)) begin
      pend = 1; p_a = maddr[7:0]; p_d = dq_o; p_drv = dq_oe; p_hi = hi_n; p_lo = lo_n;
    end else if (pend) begin
      if (!p_lo) mem[p_a][7:0]  = p_drv ? p_d[7:0]  : 8'hEE;
      if (!p_hi) mem[p_a][15:8] = p_drv ? p_d[15:8] : 8'hEE;
      pend = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [16:0] a, input logic [15:0] d,
                     input logic [1:0] m);
    int n_cs = 0, n_busy = 0, n_dq = 0, first_dq = -1, bad_pins = 0, bad_dq = 0;
    int bad_rd = 0, c_rsp = -1;
    logic [15:0] got = '0;
    @(negedge clk);
    chk(ready == 1'b1, "R7", "ready before request", ready, 1);
    valid = 1'b1; we = wr; addr = a; wdata = d; be = m;
    @(negedge clk);
    valid = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (!ready) n_busy++;
      if (!cs_n) begin
        n_cs++;
        if ({hi_n, lo_n} != ~m || maddr != a) bad_pins++;
        if (wr ? (wr_n || !rd_n) : (!wr_n || rd_n)) bad_pins++;
      end else if (!(hi_n && lo_n) || !wr_n || !rd_n) bad_pins++;
      if (dq_oe) begin
        n_dq++;
        if (first_dq < 0) first_dq = c;
        if (dq_o != d) bad_dq++;
        if (!rd_n) bad_rd++;
      end
      if (rsp_valid) begin c_rsp = c; got = rdata; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "response is one cycle", rsp_valid, 0);
    if (m == 2'b00) begin
      chk(n_cs == 0 && bad_pins == 0, "R8", "no strobes for empty mask", n_cs, 0);
      chk(n_busy == 0 && c_rsp == 0, "R8", "immediate response", c_rsp, 0);
      chk(got == 16'h0, "R8", "empty mask data", got, 0);
    end else if (wr) begin
      chk(bad_pins == 0, "R4", "write strobes/address (R10)", bad_pins, 0);
      chk(n_cs == E_WP, "R9", "write pulse cycles (R4)", n_cs, E_WP);
      chk(n_dq == E_WP && first_dq == 1, "R5", "drive window", first_dq, 1);
      chk(bad_dq == 0, "R5", "driven data", bad_dq, 0);
      chk(bad_rd == 0, "R6", "drive while read-strobe low", bad_rd, 0);
      chk(n_busy == E_WP + E_REC && c_rsp == E_WP + E_REC, "R7", "write busy cycles",
          n_busy, E_WP + E_REC);
      if (!m[0]) shadow[a[7:0]][7:0] = shadow[a[7:0]][7:0];
      else       shadow[a[7:0]][7:0] = d[7:0];
      if (m[1])  shadow[a[7:0]][15:8] = d[15:8];
    end else begin
      chk(bad_pins == 0, "R2", "read strobes/address (R10)", bad_pins, 0);
      chk(n_cs == E_RD, "R9", "read strobe cycles (R2)", n_cs, E_RD);
      chk(n_busy == E_RD && c_rsp == E_RD, "R7", "read busy cycles", n_busy, E_RD);
      chk(got == (shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}}), "R3", "lane read data",
          got, shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}});
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0301) ^ 16'h3C00;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(cs_n && rd_n && wr_n && hi_n && lo_n, "R1", "strobes in reset",
        {cs_n, rd_n, wr_n, hi_n, lo_n}, 5'h1f);
    chk(!dq_oe && !rsp_valid && ready, "R1", "drive/resp/ready in reset",
        {dq_oe, rsp_valid, ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && rd_n && wr_n && hi_n && lo_n && !dq_oe && ready, "R1", "idle after reset",
        {cs_n, rd_n, wr_n, hi_n, lo_n, dq_oe, ready}, 7'h7d);
    chk(E_RD == (GRADE == 0 ? 18 : 22) && E_WP == (GRADE == 0 ? 17 : 18), "R9",
        "derived counts", E_WP, GRADE == 0 ? 17 : 18);
    for (int a = 0; a < 8; a++) begin
      for (int m = 0; m < 4; m++) begin
        run(1'b1, 17'(a | (a << 13) | (m << 9)) & 17'h1e0ff | 17'(a),
            16'(16'hA000 + a * 16'h0111 + m * 16'h1E0F), 2'(m));
        for (int r = 0; r < 4; r++)
          run(1'b0, 17'(a | (r << 10)), 16'hFFFF, 2'(r));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule